// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits between a set of single-cycle interrupt request lines and one processor core. Every line carries a small priority value. A group-split setting cuts that value in two: the upper bits form the preemption level, which decides whether a new request may interrupt a running handler, and the lower bits form a sub-priority, which only orders requests that share a level. The controller offers one line number at a time. The core takes the offer with an accept strobe and reports the end of a handler with a return strobe.

Accepted lines go onto a stack of active handlers. Each new entry must sit at a strictly more urgent preemption level than the entry below it, so the stack never holds more entries than there are levels. When a handler returns, the entry below it becomes the running context again. If a pending line beats that restored level, the controller offers it on a short tail-chain path and does not pass through the normal entry delay. A global mask can hold back every line whose priority value reaches a threshold, except lines at the most urgent value.

The controller is a three-state machine:
- **Idle** means nothing is being offered.
- **Entry** counts the entry delay while it keeps choosing the best eligible line.
- **Offer** presents the chosen line until the core accepts it.

The transitions are:
- **take** (Idle to Entry): a pending line beats the running level.
- **chain** (Idle to Entry on a return, with the counter preloaded): a pending line beats the level that the return restores.
- **drop** (Entry to Idle): no line is eligible any longer.
- **ready** (Entry to Offer): the delay has run out.
- **accept** (Offer to Idle): the core takes the line.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, no line is pending or active, `vec_valid` is 0 and `run_valid` is 0.
- R2: A smaller priority value is more urgent. With `grp_sel` = g, the low g bits of a line's priority are its sub-priority and the remaining upper bits (the value shifted right by g) are its preemption level. Only the preemption level decides nesting.
- R3: A pending line whose preemption level is strictly more urgent than the running handler's level is offered while that handler runs. After it is accepted, `run_id` shows it. When it returns, `run_id` shows the preempted line again.
- R4: A pending line whose preemption level equals or is less urgent than the running handler's level is never offered while that handler runs.
- R5: On a return, if a pending line beats the restored level (or nothing remains active), the best such line is offered, and `vec_valid` is first high after the CHAIN_LAT-th rising edge, counting the edge that samples `core_ret` as the first.
- R6: Among eligible lines, the line with the smallest full priority value (preemption level first, then sub-priority) wins. On an exact tie, the lower line index wins.
- R7: With no handler active, a request pulse on an eligible line makes `vec_valid` first high after the ENTRY_LAT-th rising edge, counting the edge that samples the pulse as the first.
- R8: A pulse sets the line's `pend_vec` bit, and the accept clears it. A pulse in the same cycle as the accept, or while the line is active, leaves the bit set, so the line runs again after it returns.
- R9: While `mask_en` is 1, a line whose priority value is greater than or equal to `mask_level` and not 0 is never offered. A line with priority value 0 is never masked.
- R10: An offer holds `vec_id` steady until it is accepted. `core_ack` without an offer and `core_ret` with no active handler change nothing.
- R11: `act_vec` marks exactly the lines on the active stack. `run_level` gives the preemption level of the running handler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pulse | input | NUM_IRQ | One-cycle request pulses, one per line |
| prio_cfg | input | NUM_IRQ*PRIO_W | Priority value of line i at bits [i*PRIO_W +: PRIO_W] |
| grp_sel | input | $clog2(PRIO_W) | Number of low priority bits used as sub-priority |
| mask_en | input | 1 | Enables the global threshold mask |
| mask_level | input | PRIO_W | Mask threshold value |
| core_ack | input | 1 | Core accepts the offered line |
| core_ret | input | 1 | Core returns from the running handler |
| vec_valid | output | 1 | A line is being offered |
| vec_id | output | $clog2(NUM_IRQ) | Offered line number |
| run_valid | output | 1 | At least one handler is active |
| run_id | output | $clog2(NUM_IRQ) | Line of the running (innermost) handler |
| run_level | output | PRIO_W | Preemption level of the running handler |
| pend_vec | output | NUM_IRQ | Per-line pending bits |
| act_vec | output | NUM_IRQ | Per-line active bits |

## Verification
The bench builds the controller with four lines, 3-bit priorities, an entry delay of 12 and a tail-chain delay of 4. This makes the active stack eight deep and allows group settings of 0, 1 and 2 sub-priority bits. With that configuration, the bench can sweep every non-empty set of simultaneous requests under five priority assignments (one of them all-equal) and every group setting. It checks the full serve sequence, and it checks the entry and chain delays cycle by cycle against an order it sorts itself. Directed sequences cover the remaining cases: two-deep nesting, a request that ties the running level, a request that arrives in the same cycle as its own accept, and the threshold mask with its unmaskable value 0.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ENTRY = 2'd1,
        ST_OFFER = 2'd2
    } pic_state_e;

endpackage

// File: rtl/pic_arbiter.sv
`timescale 1ns/1ps
// Picks the most urgent candidate: smallest priority value, lowest index on ties.
module pic_arbiter #(
    parameter int NUM_IRQ = 8,
    parameter int PRIO_W  = 4,
    localparam int IDW    = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0]        cand,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio,
    output logic                      found,
    output logic [IDW-1:0]            win_id,
    output logic [PRIO_W-1:0]         win_prio
);

    always_comb begin
        found    = 1'b0;
        win_id   = '0;
        win_prio = '1;
        for (int i = 0; i < NUM_IRQ; i++) begin
            // strict compare keeps the lower index on an exact tie
            if (cand[i] && (!found || (prio[i*PRIO_W +: PRIO_W] < win_prio))) begin
                found    = 1'b1;
                win_id   = IDW'(i);
                win_prio = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/pic_stack.sv
`timescale 1ns/1ps
// Stack of active line numbers; innermost handler on top.
module pic_stack #(
    parameter int NUM_IRQ = 8,
    parameter int DEPTH   = 16,
    localparam int IDW    = $clog2(NUM_IRQ),
    localparam int AW     = $clog2(DEPTH),
    localparam int PTRW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    input  logic [IDW-1:0]  push_id,
    output logic [PTRW-1:0] depth,
    output logic [IDW-1:0]  top_id,
    output logic [IDW-1:0]  under_id
);

    logic [IDW-1:0]  mem [DEPTH];
    logic [PTRW-1:0] ptr_q;
    logic [PTRW-1:0] top_idx;
    logic [PTRW-1:0] under_idx;
    logic            pop_eff;

    assign pop_eff   = pop && (ptr_q != '0);
    assign top_idx   = ptr_q - PTRW'(1);
    assign under_idx = ptr_q - PTRW'(2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (pop_eff && push) begin
            mem[top_idx[AW-1:0]] <= push_id;
        end else if (push) begin
            mem[ptr_q[AW-1:0]] <= push_id;
            ptr_q <= ptr_q + PTRW'(1);
        end else if (pop_eff) begin
            ptr_q <= top_idx;
        end
    end

    assign depth    = ptr_q;
    assign top_id   = (ptr_q != '0) ? mem[top_idx[AW-1:0]] : '0;
    assign under_id = (ptr_q > PTRW'(1)) ? mem[under_idx[AW-1:0]] : '0;

    // a push onto a full stack would mean two entries share one level
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop_eff) |-> (ptr_q < PTRW'(DEPTH)));

    p_depth_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= PTRW'(DEPTH));

endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int NUM_IRQ   = 8,
    parameter int PRIO_W    = 4,
    parameter int ENTRY_LAT = 12,
    parameter int CHAIN_LAT = 4,
    localparam int IDW      = $clog2(NUM_IRQ),
    localparam int GW       = $clog2(PRIO_W)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_IRQ-1:0]        irq_pulse,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_cfg,
    input  logic [GW-1:0]             grp_sel,
    input  logic                      mask_en,
    input  logic [PRIO_W-1:0]         mask_level,
    input  logic                      core_ack,
    input  logic                      core_ret,
    output logic                      vec_valid,
    output logic [IDW-1:0]            vec_id,
    output logic                      run_valid,
    output logic [IDW-1:0]            run_id,
    output logic [PRIO_W-1:0]         run_level,
    output logic [NUM_IRQ-1:0]        pend_vec,
    output logic [NUM_IRQ-1:0]        act_vec
);

    localparam int DEPTH       = 1 << PRIO_W;
    localparam int PTRW        = $clog2(DEPTH + 1);
    localparam int CW          = $clog2(ENTRY_LAT);
    localparam int OFFER_AT    = ENTRY_LAT - 3;
    localparam int CHAIN_START = ENTRY_LAT - 1 - CHAIN_LAT;

    function automatic logic [PRIO_W-1:0] pre_of(input logic [PRIO_W-1:0] p,
                                                  input logic [GW-1:0] g);
        return p >> g;
    endfunction

    // ---------------- per-line state ----------------
    logic [NUM_IRQ-1:0] pend_q, act_q;
    logic [NUM_IRQ-1:0] blocked, cand;
    logic [PRIO_W-1:0]  line_prio [NUM_IRQ];

    for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_line
        assign line_prio[gi] = prio_cfg[gi*PRIO_W +: PRIO_W];
        assign blocked[gi]   = mask_en && (line_prio[gi] >= mask_level) && (line_prio[gi] != '0);
    end

    assign cand = pend_q & ~blocked;

    // ---------------- arbitration ----------------
    logic              win_found;
    logic [IDW-1:0]    win_id;
    logic [PRIO_W-1:0] win_prio;

    pic_arbiter #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_arb (
        .cand    (cand),
        .prio    (prio_cfg),
        .found   (win_found),
        .win_id  (win_id),
        .win_prio(win_prio)
    );

    // ---------------- active stack ----------------
    logic            stk_push, stk_pop;
    logic [PTRW-1:0] stk_depth;
    logic [IDW-1:0]  top_id, under_id;
    logic [IDW-1:0]  sel_q, sel_d;

    pic_stack #(.NUM_IRQ(NUM_IRQ), .DEPTH(DEPTH)) u_stk (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (stk_push),
        .pop     (stk_pop),
        .push_id (sel_q),
        .depth   (stk_depth),
        .top_id  (top_id),
        .under_id(under_id)
    );

    logic              stk_empty, ret_eff;
    logic [PRIO_W-1:0] top_pre, under_pre, win_pre;
    logic              take_now, chain_ok;

    assign stk_empty = (stk_depth == '0);
    assign ret_eff   = core_ret && !stk_empty;
    assign top_pre   = stk_empty ? '0 : pre_of(line_prio[top_id], grp_sel);
    assign under_pre = pre_of(line_prio[under_id], grp_sel);
    assign win_pre   = pre_of(win_prio, grp_sel);
    // eligible against the running level
    assign take_now  = win_found && (stk_empty || (win_pre < top_pre));
    // eligible against the level a return restores
    assign chain_ok  = win_found && ((stk_depth == PTRW'(1)) || (win_pre < under_pre));

    // ---------------- state machine ----------------
    pic_state_e      state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sel_q   <= sel_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        sel_d   = sel_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ret_eff) begin
                    if (chain_ok) begin           // chain
                        state_d = ST_ENTRY;
                        cnt_d   = CW'(CHAIN_START);
                        sel_d   = win_id;
                    end
                end else if (take_now) begin      // take
                    state_d = ST_ENTRY;
                    cnt_d   = '0;
                    sel_d   = win_id;
                end
            end
            ST_ENTRY: begin
                if (ret_eff ? chain_ok : take_now) begin
                    sel_d = win_id;               // late arrival may replace the choice
                    if (cnt_q == CW'(OFFER_AT)) begin
                        state_d = ST_OFFER;       // ready
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end else begin
                    state_d = ST_IDLE;            // drop
                end
            end
            ST_OFFER: begin
                if (core_ack) state_d = ST_IDLE;  // accept
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs and bookkeeping strobes ----------------
    logic [NUM_IRQ-1:0] set_act, clr_act;

    always_comb begin
        vec_valid = (state_q == ST_OFFER);
        vec_id    = sel_q;
        stk_push  = (state_q == ST_OFFER) && core_ack;
        stk_pop   = ret_eff;
        set_act   = stk_push ? (NUM_IRQ'(1) << sel_q) : '0;
        clr_act   = stk_pop  ? (NUM_IRQ'(1) << top_id) : '0;
        run_valid = !stk_empty;
        run_id    = top_id;
        run_level = top_pre;
        pend_vec  = pend_q;
        act_vec   = act_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            act_q  <= '0;
        end else begin
            pend_q <= (pend_q & ~set_act) | irq_pulse;
            act_q  <= (act_q & ~clr_act) | set_act;
        end
    end

    // ---------------- assertions ----------------
    p_offer_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !core_ack) |=> (vec_valid && $stable(vec_id)));

    p_nest_deeper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && core_ack && run_valid && !core_ret) |=> (run_level < $past(run_level)));

    p_accept_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && core_ack && !irq_pulse[vec_id]) |=> !pend_vec[$past(vec_id)]);

    p_offer_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> pend_vec[vec_id]);

    p_active_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(act_vec) == int'(stk_depth));

endmodule

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;

    localparam int N   = 4;
    localparam int PW  = 3;
    localparam int LAT = 12;
    localparam int CL  = 4;
    localparam int IDW = $clog2(N);
    localparam int GW  = $clog2(PW);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      irq_pulse = '0;
    logic [N*PW-1:0]   prio_cfg = '0;
    logic [GW-1:0]     grp_sel = '0;
    logic              mask_en = 1'b0;
    logic [PW-1:0]     mask_level = '0;
    logic              core_ack = 1'b0;
    logic              core_ret = 1'b0;
    logic              vec_valid, run_valid;
    logic [IDW-1:0]    vec_id, run_id;
    logic [PW-1:0]     run_level;
    logic [N-1:0]      pend_vec, act_vec;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    prio_irq_ctrl #(.NUM_IRQ(N), .PRIO_W(PW), .ENTRY_LAT(LAT), .CHAIN_LAT(CL)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_pulse(irq_pulse), .prio_cfg(prio_cfg),
        .grp_sel(grp_sel), .mask_en(mask_en), .mask_level(mask_level),
        .core_ack(core_ack), .core_ret(core_ret), .vec_valid(vec_valid),
        .vec_id(vec_id), .run_valid(run_valid), .run_id(run_id),
        .run_level(run_level), .pend_vec(pend_vec), .act_vec(act_vec)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_prio(input int p0, input int p1, input int p2, input int p3);
        prio_cfg = {PW'(p3), PW'(p2), PW'(p1), PW'(p0)};
    endtask

    task automatic pulse(input logic [N-1:0] bits);
        @(negedge clk); irq_pulse = bits;
        @(posedge clk); @(negedge clk); irq_pulse = '0;
    endtask

    task automatic expect_offer(input int edges, input int exp_id, input string tag);
        bit early = 1'b0;
        for (int j = 0; j < edges - 1; j++) begin
            @(posedge clk); @(negedge clk);
            if (vec_valid) early = 1'b1;
        end
        @(posedge clk); @(negedge clk);
        chk(!early && vec_valid && int'(vec_id) == exp_id, tag,
            (vec_valid && !early) ? int'(vec_id) : -1, exp_id);
    endtask

    task automatic expect_none(input int edges, input string tag);
        bit seen = 1'b0;
        for (int j = 0; j < edges; j++) begin
            @(posedge clk); @(negedge clk);
            if (vec_valid) seen = 1'b1;
        end
        chk(!seen, tag, int'(seen), 0);
    endtask

    task automatic accept();
        core_ack = 1'b1; @(posedge clk); @(negedge clk); core_ack = 1'b0;
    endtask

    task automatic do_ret();
        core_ret = 1'b1; @(posedge clk); @(negedge clk); core_ret = 1'b0;
    endtask

    function automatic int prio_at(input int i);
        return int'(prio_cfg[i*PW +: PW]);
    endfunction

    // all pending together, empty stack: served in ascending (priority, index)
    task automatic sweep_case(input logic [N-1:0] pat);
        int rem = int'(pat);
        int cnt = 0;
        pulse(pat);
        while (rem != 0) begin
            int best = -1;
            for (int i = 0; i < N; i++)
                if (rem[i] && (best < 0 || prio_at(i) < prio_at(best))) best = i;
            rem[best] = 1'b0;
            if (cnt == 0) expect_offer(LAT - 1, best, "R7 entry delay / R6 order");
            else          expect_offer(CL - 1, best, "R5 chain delay / R6 order");
            accept();
            do_ret();
            cnt++;
        end
        expect_none(LAT, "R6 nothing left after sweep");
        chk(pend_vec == '0 && act_vec == '0, "R11 idle after sweep",
            int'({pend_vec, act_vec}), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!vec_valid && !run_valid && pend_vec == '0 && act_vec == '0, "R1 reset state",
            int'({vec_valid, run_valid, pend_vec, act_vec}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 stray strobes
        core_ack = 1'b1; @(posedge clk); @(negedge clk); core_ack = 1'b0;
        core_ret = 1'b1; @(posedge clk); @(negedge clk); core_ret = 1'b0;
        chk(!run_valid && act_vec == '0 && pend_vec == '0 && !vec_valid,
            "R10 stray ack/ret ignored", int'({run_valid, act_vec, pend_vec}), 0);

        // R6 / R7 / R5 exhaustive sweep
        for (int g = 0; g < PW; g++) begin
            grp_sel = GW'(g);
            for (int s = 0; s < 5; s++) begin
                if (s == 4) set_prio(2, 2, 2, 2);
                else set_prio((0*(2*s+1) + 3*s) % 8, (1*(2*s+1) + 3*s) % 8,
                              (2*(2*s+1) + 3*s) % 8, (3*(2*s+1) + 3*s) % 8);
                for (int p = 1; p < (1 << N); p++) sweep_case(N'(p));
            end
        end

        // R3 / R4 / R5 / R11 nesting
        grp_sel = '0;
        set_prio(3, 5, 3, 4);
        pulse(4'b0010);
        expect_offer(LAT - 1, 1, "R7 first entry");
        accept();
        chk(run_valid && run_id == 1 && run_level == 5 && act_vec == 4'b0010,
            "R11 one active", int'(act_vec), 2);
        pulse(4'b0100);
        expect_offer(LAT - 1, 2, "R3 preempt offer");
        accept();
        chk(run_id == 2 && run_level == 3 && act_vec == 4'b0110,
            "R3 nested running / R11", int'(act_vec), 6);
        pulse(4'b1001);
        expect_none(LAT + 4, "R4 equal or lower level waits");
        do_ret();
        expect_offer(CL - 1, 0, "R5 chain past restored level");
        accept();
        chk(run_id == 0 && act_vec == 4'b0011, "R11 after chain", int'(act_vec), 3);
        do_ret();
        expect_offer(CL - 1, 3, "R5 second chain");
        accept();
        do_ret();
        chk(run_valid && run_id == 1 && run_level == 5 && act_vec == 4'b0010,
            "R3 preempted resumes", int'(run_id), 1);
        do_ret();
        chk(!run_valid && act_vec == '0, "R11 stack empty", int'(act_vec), 0);

        // R2 group split
        grp_sel = GW'(2);
        set_prio(6, 5, 3, 7);
        pulse(4'b0001);
        expect_offer(LAT - 1, 0, "R2 base entry");
        accept();
        pulse(4'b0010);
        expect_none(LAT + 4, "R2 same preempt level, different sub");
        pulse(4'b0100);
        expect_offer(LAT - 1, 2, "R2 more urgent preempt level");
        accept();
        do_ret();
        expect_none(CL + 2, "R4 no chain at equal level");
        do_ret();
        expect_offer(CL - 1, 1, "R5 chain after last return");
        accept();
        do_ret();
        grp_sel = '0;
        pulse(4'b0001);
        expect_offer(LAT - 1, 0, "R2 base entry, no sub bits");
        accept();
        pulse(4'b0010);
        expect_offer(LAT - 1, 1, "R2 full value now preempts");
        accept();
        do_ret();
        do_ret();
        chk(!run_valid, "R2 drained", int'(run_valid), 0);

        // R8 pending rules
        set_prio(4, 4, 2, 1);
        pulse(4'b0100);
        expect_offer(LAT - 1, 2, "R8 entry");
        accept();
        chk(pend_vec[2] == 1'b0, "R8 accept clears pending", int'(pend_vec[2]), 0);
        pulse(4'b0100);
        chk(pend_vec[2] == 1'b1, "R8 pulse while active", int'(pend_vec[2]), 1);
        expect_none(LAT, "R4 own line waits");
        do_ret();
        expect_offer(CL - 1, 2, "R8 runs again");
        accept();
        do_ret();
        pulse(4'b1000);
        expect_offer(LAT - 1, 3, "R8 entry line 3");
        core_ack = 1'b1; irq_pulse = 4'b1000;
        @(posedge clk); @(negedge clk);
        core_ack = 1'b0; irq_pulse = '0;
        chk(pend_vec[3] == 1'b1, "R8 pulse with accept stays pending", int'(pend_vec[3]), 1);
        do_ret();
        expect_offer(CL - 1, 3, "R8 rerun after accept pulse");
        // R10 offer held
        repeat (5) @(negedge clk);
        chk(vec_valid && vec_id == 3, "R10 offer held", int'(vec_id), 3);
        accept();
        do_ret();

        // R9 mask
        set_prio(0, 5, 6, 6);
        mask_en = 1'b1; mask_level = 3'd4;
        pulse(4'b0010);
        expect_none(LAT + 4, "R9 masked line held");
        mask_level = 3'd0;
        pulse(4'b0001);
        expect_offer(LAT - 1, 0, "R9 value 0 unmaskable");
        accept();
        do_ret();
        expect_none(CL + 2, "R9 masked line not chained");
        @(negedge clk); mask_en = 1'b0;
        expect_offer(LAT - 1, 1, "R9 released by unmask");
        accept();
        do_ret();
        chk(pend_vec == '0 && act_vec == '0, "R9 drained", int'(pend_vec), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule